// File: doc/BRIEF.md
# Carry-Aware Shift and Add Unit

This block is the 8-bit arithmetic slice of a small accumulator-style processor core. It covers four kinds of work. Plain addition and subtraction, and the same two with the current carry (or borrow) folded in. Nine-bit rotates that pass through the carry flag. Three true shifts: arithmetic right, logical right and logical left. The core presents an operation code, the W operand, a second operand, a flag that says whether that second operand is a literal, a destination flag and the present carry. One clock later the unit returns the result, new carry, digit-carry and zero flags, plus a write-target indication.

Subtraction treats carry as "not borrow". The carry-in forms accept only a register operand. A request that pairs one of them with a literal is refused, as is any unused operation code. A refused request leaves every result and flag register untouched and raises a one-cycle reject pulse. Register file, fetch and writeback live outside the block.

Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 rotate left through carry, 5 rotate right through carry, 6 arithmetic right shift, 7 logical right shift, 8 logical left shift, 9 arithmetic left shift. Codes 10 to 15 are unused.

Top module: `shalu_unit`

## Requirements
- R1: Op 0 (add): result = (f + w) mod 256. C is the carry out of bit 7. DC is the carry out of bit 3. Z = (result == 0).
- R2: Op 1 (add with carry): as R1 but computes f + w + C_in, and the carry-in also enters the bit-3 digit carry.
- R3: Op 2 (subtract): result = (f - w) mod 256. C = 1 when f >= w (no borrow). DC = 1 when f[3:0] >= w[3:0]. Z = (result == 0).
- R4: Op 3 (subtract with borrow): result = (f - w - (1 - C_in)) mod 256. C = 1 when no borrow occurs. DC = 1 when the low nibble does not borrow, with the borrow-in applied. Z = (result == 0).
- R5: Op 4 gives {f[6:0], C_in} with C = f[7]. Op 5 gives {C_in, f[7:1]} with C = f[0]. Z and DC hold their previous values. Nine chained rotates in one direction restore the original value and carry.
- R6: Op 6 (arithmetic right): result = {f[7], f[7:1]}, C = f[0], Z = (result == 0), DC holds.
- R7: Op 7 (logical right): result = {0, f[7:1]}, C = f[0], Z = (result == 0), DC holds.
- R8: Ops 8 and 9 both give {f[6:0], 0} with C = f[7] and Z = (result == 0), and they yield identical outputs. DC holds.
- R9: A request is refused when lit_i=1 with op 1 or op 3, or when op is 10 to 15. A refused request produces reject_o=1 and done_o=0 one cycle later, and result, C, DC, Z and wr_file_o stay unchanged. Ops 0 and 2 accept a literal.
- R10: An accepted request updates the outputs on the clock edge that samples it, and done_o pulses for that one cycle. wr_file_o takes dest_file_i. With op_valid_i=0 all outputs except done_o and reject_o hold, and done_o and reject_o are 0.
- R11: While reset is applied, result_o, carry_o, dcarry_o, zero_o, wr_file_o, done_o and reject_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | W operand |
| f_i | input | 8 | Register or literal operand |
| lit_i | input | 1 | f_i holds a literal |
| dest_file_i | input | 1 | Result goes to the register file (else to W) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result |
| carry_o | output | 1 | Carry / not-borrow flag |
| dcarry_o | output | 1 | Digit carry out of bit 3 |
| zero_o | output | 1 | Zero flag |
| wr_file_o | output | 1 | Destination of the last accepted result |
| done_o | output | 1 | Accepted-request pulse |
| reject_o | output | 1 | Refused-request pulse |

## Verification
Every result, every flag, and the done and reject pulses are due on the first rising edge after the request is presented. Nothing in the unit takes longer. The bench drives each request on a falling edge and compares all outputs on the next falling edge, half a cycle after the registers load. A model in the bench tracks which flags an operation leaves alone, so a held value is checked in the same cycle as a changed one. Chained rotates feed the sampled carry back as the next carry input. That exercises the nine-step wraparound under the same one-cycle timing.

// File: rtl/shalu_pkg.sv
package shalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_RLC  = 4'd4,
    OP_RRC  = 4'd5,
    OP_ASR  = 4'd6,
    OP_LSR  = 4'd7,
    OP_LSL  = 4'd8,
    OP_ASL  = 4'd9
  } op_e;

  typedef struct packed {
    logic arith;
    logic subtract;
    logic use_cin;
    logic rotate;
    logic shift;
    logic refuse;
  } ctl_t;
endpackage

// File: rtl/shalu_decode.sv
module shalu_decode
  import shalu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       lit_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_ADD:  ctl_o.arith = 1'b1;
      OP_ADDC: begin ctl_o.arith = 1'b1; ctl_o.use_cin = 1'b1; ctl_o.refuse = lit_i; end
      OP_SUB:  begin ctl_o.arith = 1'b1; ctl_o.subtract = 1'b1; end
      OP_SUBB: begin ctl_o.arith = 1'b1; ctl_o.subtract = 1'b1; ctl_o.use_cin = 1'b1;
                     ctl_o.refuse = lit_i; end
      OP_RLC, OP_RRC: ctl_o.rotate = 1'b1;
      OP_ASR, OP_LSR, OP_LSL, OP_ASL: ctl_o.shift = 1'b1;
      default: ctl_o.refuse = 1'b1;
    endcase
  end
endmodule

// File: rtl/shalu_adder.sv
module shalu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             invert_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             dcout_o
);
  localparam int NIB = 4;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;
  logic [NIB:0]     low;

  always_comb begin
    b_eff   = invert_b_i ? ~b_i : b_i;
    full    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
    low     = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    sum_o   = full[WIDTH-1:0];
    cout_o  = full[WIDTH];
    dcout_o = low[NIB];
  end
endmodule

// File: rtl/shalu_shifter.sv
module shalu_shifter
  import shalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o  = f_i;
    cout_o = cin_i;
    case (op_i)
      OP_RLC:         begin res_o = {f_i[MSB-1:0], cin_i}; cout_o = f_i[MSB]; end
      OP_RRC:         begin res_o = {cin_i, f_i[MSB:1]};   cout_o = f_i[0];   end
      OP_ASR:         begin res_o = {f_i[MSB], f_i[MSB:1]}; cout_o = f_i[0];  end
      OP_LSR:         begin res_o = {1'b0, f_i[MSB:1]};    cout_o = f_i[0];   end
      OP_LSL, OP_ASL: begin res_o = {f_i[MSB-1:0], 1'b0};  cout_o = f_i[MSB]; end
      default:        begin res_o = f_i; cout_o = cin_i; end
    endcase
  end
endmodule

// File: rtl/shalu_unit.sv
module shalu_unit
  import shalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] f_i,
  input  logic             lit_i,
  input  logic             dest_file_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             dcarry_o,
  output logic             zero_o,
  output logic             wr_file_o,
  output logic             done_o,
  output logic             reject_o
);
  localparam int SYNC = 2;

  logic [SYNC-1:0] rst_pipe;
  logic            rst_n_s;
  ctl_t            ctl;
  logic [WIDTH-1:0] add_sum, sh_res;
  logic            add_c, add_dc, sh_c, add_cin;

  logic [WIDTH-1:0] result_n;
  logic carry_n, dcarry_n, zero_n, wr_file_n, done_n, reject_n, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC-1];

  shalu_decode u_dec (.op_i(op_i), .lit_i(lit_i), .ctl_o(ctl));

  assign add_cin = ctl.use_cin ? carry_i : ctl.subtract;

  shalu_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(f_i), .b_i(w_i), .invert_b_i(ctl.subtract), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_c), .dcout_o(add_dc)
  );

  shalu_shifter #(.WIDTH(WIDTH)) u_shf (
    .op_i(op_i), .f_i(f_i), .cin_i(carry_i), .res_o(sh_res), .cout_o(sh_c)
  );

  assign accept = op_valid_i && !ctl.refuse;

  always_comb begin
    result_n  = result_o;
    carry_n   = carry_o;
    dcarry_n  = dcarry_o;
    zero_n    = zero_o;
    wr_file_n = wr_file_o;
    done_n    = accept;
    reject_n  = op_valid_i && ctl.refuse;
    if (accept) begin
      wr_file_n = dest_file_i;
      if (ctl.arith) begin
        result_n = add_sum;
        carry_n  = add_c;
        dcarry_n = add_dc;
        zero_n   = (add_sum == '0);
      end else begin
        result_n = sh_res;
        carry_n  = sh_c;
        if (ctl.shift) zero_n = (sh_res == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      result_o  <= '0;
      carry_o   <= 1'b0;
      dcarry_o  <= 1'b0;
      zero_o    <= 1'b0;
      wr_file_o <= 1'b0;
      done_o    <= 1'b0;
      reject_o  <= 1'b0;
    end else begin
      result_o  <= result_n;
      carry_o   <= carry_n;
      dcarry_o  <= dcarry_n;
      zero_o    <= zero_n;
      wr_file_o <= wr_file_n;
      done_o    <= done_n;
      reject_o  <= reject_n;
    end
  end
endmodule

// File: rtl/shalu_checker.sv
module shalu_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] w_i,
  input logic [WIDTH-1:0] f_i,
  input logic             lit_i,
  input logic             dest_file_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             dcarry_o,
  input logic             zero_o,
  input logic             wr_file_o,
  input logic             done_o,
  input logic             reject_o
);
  logic refused_req;
  assign refused_req = op_valid_i &&
    ((op_i > 4'd9) || (lit_i && (op_i == 4'd1 || op_i == 4'd3)));

  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    refused_req |=> reject_o && !done_o && $stable(result_o) && $stable(carry_o)
                    && $stable(zero_o) && $stable(dcarry_o)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !done_o && !reject_o && $stable(result_o) && $stable(carry_o)
                    && $stable(wr_file_o)); // R10

  AST_ASR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == 4'd6) |=>
      (done_o -> (result_o[WIDTH-1] == $past(f_i[WIDTH-1]) && carry_o == $past(f_i[0])))); // R6

  AST_LSR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == 4'd7) |=>
      (done_o -> (!result_o[WIDTH-1] && carry_o == $past(f_i[0])))); // R7

  AST_ASL_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == 4'd9) |=>
      (done_o -> (result_o == {$past(f_i[WIDTH-2:0]), 1'b0} && carry_o == $past(f_i[WIDTH-1])))); // R8

  AST_ROT_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_i == 4'd4 || op_i == 4'd5)) |=>
      ($stable(zero_o) && $stable(dcarry_o))); // R5

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && reject_o)); // R10
endmodule

bind shalu_unit shalu_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/shalu_unit_test.sv
`timescale 1ns/1ps
module shalu_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid_i;
  logic [3:0] op_i;
  logic [7:0] w_i, f_i;
  logic       lit_i, dest_file_i, carry_i;
  logic [7:0] result_o;
  logic       carry_o, dcarry_o, zero_o, wr_file_o, done_o, reject_o;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  logic [7:0] m_res;
  logic m_c, m_dc, m_z, m_wr;

  always #2.5 clk = ~clk;

  shalu_unit uut (.*);

  task automatic put(input bit valid, input logic [3:0] op, input logic [7:0] w,
                     input logic [7:0] f, input bit cin, input bit lit, input bit dest);
    bit rej, acc, e_done, e_rej;
    logic [8:0] s;
    logic [4:0] ln;
    logic ci;
    string req;
    rej = valid && ((op > 4'd9) || (lit && (op == 4'd1 || op == 4'd3)));
    acc = valid && !rej;
    e_done = acc; e_rej = rej;
    case (op)
      4'd0: req = "R1"; 4'd1: req = "R2"; 4'd2: req = "R3"; 4'd3: req = "R4";
      4'd4, 4'd5: req = "R5"; 4'd6: req = "R6"; 4'd7: req = "R7";
      4'd8, 4'd9: req = "R8"; default: req = "R9";
    endcase
    if (rej) req = "R9";
    if (!valid) req = "R10";
    if (acc) begin
      m_wr = dest;
      case (op)
        4'd0, 4'd1: begin
          ci = (op == 4'd1) ? cin : 1'b0;
          s  = {1'b0, f} + {1'b0, w} + {8'd0, ci};
          ln = {1'b0, f[3:0]} + {1'b0, w[3:0]} + {4'd0, ci};
          m_res = s[7:0]; m_c = s[8]; m_dc = ln[4]; m_z = (s[7:0] == 0);
        end
        4'd2, 4'd3: begin
          ci = (op == 4'd3) ? ~cin : 1'b0;
          m_res = f - w - {7'd0, ci};
          m_c  = ({1'b0, f} >= ({1'b0, w} + {8'd0, ci}));
          m_dc = ({1'b0, f[3:0]} >= ({1'b0, w[3:0]} + {4'd0, ci}));
          m_z  = (m_res == 0);
        end
        4'd4: begin m_res = {f[6:0], cin}; m_c = f[7]; end
        4'd5: begin m_res = {cin, f[7:1]}; m_c = f[0]; end
        4'd6: begin m_res = {f[7], f[7:1]}; m_c = f[0]; m_z = (m_res == 0); end
        4'd7: begin m_res = f >> 1; m_c = f[0]; m_z = (m_res == 0); end
        default: begin m_res = f << 1; m_c = f[7]; m_z = (m_res == 0); end
      endcase
    end
    op_valid_i = valid; op_i = op; w_i = w; f_i = f;
    carry_i = cin; lit_i = lit; dest_file_i = dest;
    @(negedge clk);
    vectors++;
    if (result_o !== m_res || carry_o !== m_c || dcarry_o !== m_dc || zero_o !== m_z ||
        wr_file_o !== m_wr || done_o !== e_done || reject_o !== e_rej) begin
      fails++;
      $display("FAIL %s op=%0d w=%h f=%h ci=%0b lit=%0b: got res=%h c%0b dc%0b z%0b wr%0b d%0b r%0b exp res=%h c%0b dc%0b z%0b wr%0b d%0b r%0b",
               req, op, w, f, cin, lit, result_o, carry_o, dcarry_o, zero_o, wr_file_o,
               done_o, reject_o, m_res, m_c, m_dc, m_z, m_wr, e_done, e_rej);
    end
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic c;
    rst_n = 1'b0; op_valid_i = 0; op_i = 0; w_i = 0; f_i = 0;
    lit_i = 0; dest_file_i = 0; carry_i = 0;
    m_res = 0; m_c = 0; m_dc = 0; m_z = 0; m_wr = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    vectors++;
    if (result_o !== 0 || carry_o || dcarry_o || zero_o || wr_file_o || done_o || reject_o) begin
      fails++;
      $display("FAIL R11 reset state res=%h c%0b dc%0b z%0b exp all zero", result_o, carry_o, dcarry_o, zero_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 R2 R3 R4: arithmetic sweep
    for (int op = 0; op < 4; op++)
      for (int f = 0; f < 256; f++)
        for (int wi = 0; wi < 16; wi++)
          for (int ci = 0; ci < 2; ci++)
            put(1, op[3:0], 8'(wi * 17), f[7:0], ci[0], 0, f[0] ^ wi[0]);
    // R5 R6 R7 R8: rotates and shifts, literal tag ignored
    for (int op = 4; op < 10; op++)
      for (int f = 0; f < 256; f++)
        for (int ci = 0; ci < 2; ci++)
          put(1, op[3:0], 8'h5a, f[7:0], ci[0], f[1], f[2]);
    // R8: alias pair on identical inputs
    put(1, 4'd8, 0, 8'h81, 0, 0, 1);
    put(1, 4'd9, 0, 8'h81, 0, 0, 1);
    // R9: literal with carry forms, unused codes, plain forms with literal
    put(1, 4'd0, 8'h10, 8'h0f, 1, 0, 1);
    put(1, 4'd1, 8'h22, 8'h33, 1, 1, 0);
    put(1, 4'd3, 8'h01, 8'h00, 0, 1, 0);
    for (int op = 10; op < 16; op++) put(1, op[3:0], 8'hff, 8'h01, 1, 0, 0);
    put(1, 4'd0, 8'h01, 8'hff, 0, 1, 0);
    put(1, 4'd2, 8'h05, 8'h03, 0, 1, 1);
    // R10: idle cycles with changing inputs
    put(0, 4'd0, 8'hff, 8'h01, 1, 0, 0);
    put(0, 4'd7, 8'h12, 8'h34, 0, 0, 0);
    // R5: nine chained rotates restore value and carry
    for (int dir = 4; dir < 6; dir++)
      for (int seed = 0; seed < 4; seed++) begin
        v = 8'(seed * 73 + 5); c = seed[0];
        put(1, 4'd0, 8'd0, 8'd0, 0, 0, 0);
        for (int k = 0; k < 9; k++) begin
          put(1, dir[3:0], 8'd0, (k == 0) ? v : result_o, (k == 0) ? c : carry_o, 0, 1);
        end
        vectors++;
        if (result_o !== v || carry_o !== c) begin
          fails++;
          $display("FAIL R5 nine rotates got %h/%0b exp %h/%0b", result_o, carry_o, v, c);
        end
      end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    finished = 1;
    $finish;
  end
endmodule